// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a 16-bit processor that finishes one instruction per clock. On every rising edge it picks the next instruction address. It has three choices: the following word, an absolute target read from a source register, or a PC-relative target that depends on one ALU status flag.

The instruction decoder drives two controls. `pc_load` asks for a change of flow, and `branch_mode` chooses between the unconditional and the conditional form. The ALU supplies its carry, negative, overflow and zero flags. The register file supplies the value of the register named by the instruction's middle source field.

A conditional branch builds a signed 6-bit displacement from the two outer register fields of the instruction. Three instruction bits choose the flag to test, and their top bit does not change the choice. A synchronous reset puts the counter at address zero.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 on that edge and stays 0 for as long as `rst` stays high.
- R2: With `pc_load` = 0, `pc` advances to `pc + 1` modulo 2^16, so 0xFFFF goes to 0x0000. `branch_mode`, the flags, `instr` and `src_a_data` have no effect.
- R3: With `pc_load` = 1 and `branch_mode` = 0 (jump), `pc` takes the value of `src_a_data`, whatever the flags and `instr` hold.
- R4: The branch displacement is the 6-bit value {`instr[8:6]`, `instr[2:0]`}, sign-extended to 16 bits. A taken branch sets `pc` to `pc + displacement` modulo 2^16.
- R5: In a conditional branch, `instr[10:9]` chooses the tested flag: 00 carry, 01 negative, 10 overflow, 11 zero. `instr[11]` does not change the choice.
- R6: With `pc_load` = 1 and `branch_mode` = 1, when the chosen flag is 0, `pc` advances to `pc + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Current instruction word |
| pc_load | input | 1 | Change-of-flow request from the decoder |
| branch_mode | input | 1 | 0 = jump, 1 = conditional branch |
| flag_c | input | 1 | ALU carry flag |
| flag_n | input | 1 | ALU negative flag |
| flag_v | input | 1 | ALU overflow flag |
| flag_z | input | 1 | ALU zero flag |
| src_a_data | input | 16 | Value of the register named by the middle source field |
| pc | output | 16 | Program counter |

## Verification
Conditional branches are run once for each flag code, with only that flag set and then with every flag except that one set. A wrong selector mapping therefore fails in one of the two runs. Codes with the high selector bit set are repeated to show that the aliasing works. The displacement is tried with a positive and a negative value, so swapped fields or a missing sign extension give wrong addresses. Plain increments run across the 0xFFFF wrap. Jumps are run with conflicting flags and instruction bits to show that only the register value matters.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int W    = 16,
  parameter int FW   = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] instr,
  input  logic         pc_load,
  input  logic         branch_mode,
  input  logic         flag_c,
  input  logic         flag_n,
  input  logic         flag_v,
  input  logic         flag_z,
  input  logic [W-1:0] src_a_data,
  output logic [W-1:0] pc
);
  localparam int OW = 2 * FW;

  logic [OW-1:0] disp;
  logic [W-1:0]  disp_ext;
  logic [W-1:0]  pc_inc;
  logic [W-1:0]  pc_rel;
  logic [3:0]    flags;
  logic          cond;
  logic          unused_bits;

  assign disp        = {instr[2*FW+2:2*FW], instr[FW-1:0]};
  assign disp_ext    = {{(W-OW){disp[OW-1]}}, disp};
  assign pc_inc      = pc + W'(1);
  assign pc_rel      = pc + disp_ext;
  assign flags       = {flag_z, flag_v, flag_n, flag_c};
  assign cond        = flags[instr[10:9]];
  assign unused_bits = ^{instr[W-1:11], instr[2*FW-1:FW]};

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (!pc_load)
      pc <= pc_inc;
    else if (!branch_mode)
      pc <= src_a_data;
    else if (cond)
      pc <= pc_rel;
    else
      pc <= pc_inc;
  end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr,
  input logic        pc_load,
  input logic        branch_mode,
  input logic        flag_c,
  input logic        flag_n,
  input logic        flag_v,
  input logic        flag_z,
  input logic [15:0] src_a_data,
  input logic [15:0] pc
);
  logic        sel_flag;
  logic [15:0] offs;

  always_comb begin
    case (instr[10:9])
      2'b00:   sel_flag = flag_c;
      2'b01:   sel_flag = flag_n;
      2'b10:   sel_flag = flag_v;
      default: sel_flag = flag_z;
    endcase
  end
  assign offs = {{10{instr[8]}}, instr[8:6], instr[2:0]};

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == 16'h0000);

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    !pc_load |=> pc == $past(pc) + 16'd1);

  a_r3_jump: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !branch_mode) |=> pc == $past(src_a_data));

  a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (pc_load && branch_mode && sel_flag) |=> pc == $past(pc) + $past(offs));

  a_r6_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
    (pc_load && branch_mode && !sel_flag) |=> pc == $past(pc) + 16'd1);
endmodule

bind pc_sequencer pc_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .pc_load(pc_load),
  .branch_mode(branch_mode), .flag_c(flag_c), .flag_n(flag_n),
  .flag_v(flag_v), .flag_z(flag_z), .src_a_data(src_a_data), .pc(pc)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic        pc_load = 1'b0;
  logic        branch_mode = 1'b0;
  logic        flag_c = 1'b0, flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0;
  logic [15:0] src_a_data = '0;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst(rst), .instr(instr), .pc_load(pc_load),
    .branch_mode(branch_mode), .flag_c(flag_c), .flag_n(flag_n),
    .flag_v(flag_v), .flag_z(flag_z), .src_a_data(src_a_data), .pc(pc)
  );

  function automatic logic [15:0] mk(input logic [2:0] sel, input logic [2:0] hi,
                                     input logic [2:0] mid, input logic [2:0] lo);
    return {4'b1010, sel, hi, mid, lo};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (pc !== exp) begin
      errors++;
      $display("FAIL %s pc=%h expected=%h", req, pc, exp);
    end
  endtask

  task automatic step(input logic r, input logic pl, input logic bm,
                      input logic [15:0] ins, input logic [3:0] zvnc,
                      input logic [15:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rst = r; pc_load = pl; branch_mode = bm; instr = ins; src_a_data = a;
    {flag_z, flag_v, flag_n, flag_c} = zvnc;
    @(posedge clk);
    #1;
    check(req, exp);
  endtask

  task automatic t_reset;
    step(1, 0, 0, 16'h0, 4'h0, 16'h0, 16'h0000, "R1");
    step(1, 1, 0, 16'hFFFF, 4'hF, 16'h1234, 16'h0000, "R1 held");
  endtask

  task automatic t_increment;
    step(0, 0, 1, 16'hFFFF, 4'hF, 16'hBEEF, 16'h0001, "R2");
    step(0, 0, 0, 16'h0E07, 4'h5, 16'h0000, 16'h0002, "R2");
    step(0, 1, 0, 16'h0, 4'h0, 16'hFFFE, 16'hFFFE, "R3 setup");
    step(0, 0, 0, 16'h0, 4'h0, 16'h0, 16'hFFFF, "R2");
    step(0, 0, 0, 16'h0, 4'h0, 16'h0, 16'h0000, "R2 wrap");
  endtask

  task automatic t_jump;
    step(0, 1, 0, mk(3'b011, 3'b111, 3'b000, 3'b111), 4'hF, 16'h4321, 16'h4321, "R3");
    step(0, 1, 0, mk(3'b000, 3'b001, 3'b010, 3'b011), 4'h0, 16'h0100, 16'h0100, "R3");
  endtask

  task automatic t_flags;
    logic [15:0] p;
    p = 16'h0100;
    for (int s = 0; s < 8; s++) begin
      logic [3:0] only;
      only = 4'b0001 << (s % 4);
      step(0, 1, 1, mk(3'(s), 3'b000, 3'b000, 3'b011), only, 16'h0, p + 16'd3, "R5 taken");
      p = p + 16'd3;
      step(0, 1, 1, mk(3'(s), 3'b000, 3'b000, 3'b011), ~only, 16'h0, p + 16'd1, "R6 not taken");
      p = p + 16'd1;
    end
  endtask

  task automatic t_offset;
    step(0, 1, 0, 16'h0, 4'h0, 16'h0200, 16'h0200, "R3 setup");
    step(0, 1, 1, mk(3'b011, 3'b001, 3'b101, 3'b010), 4'b1000, 16'h0, 16'h020A, "R4 positive");
    step(0, 1, 1, mk(3'b111, 3'b111, 3'b000, 3'b110), 4'b1000, 16'h0, 16'h0208, "R4 negative");
    step(0, 1, 1, mk(3'b111, 3'b100, 3'b000, 3'b000), 4'b1000, 16'h0, 16'h01E8, "R4 min");
    step(0, 1, 0, 16'h0, 4'h0, 16'hFFFE, 16'hFFFE, "R3 setup");
    step(0, 1, 1, mk(3'b000, 3'b000, 3'b000, 3'b101), 4'b0001, 16'h0, 16'h0003, "R4 wrap");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_increment();
        t_jump();
        t_flags();
        t_offset();
        step(1, 0, 0, 16'h0, 4'h0, 16'h0, 16'h0000, "R1 late reset");
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog pc=%h expected=done", pc);
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule